// File: doc/BRIEF.md
# Station Address Perfect-Match Filter

This block decides whether an incoming Ethernet frame should be kept, based on its 48-bit destination address. It keeps a table of sixteen station addresses. The table is loaded from a setup frame that arrives one byte at a time. Each table entry sits in a fixed 12-byte slot of that frame, and only six of the twelve byte positions in a slot carry address bytes. The rest are padding.

A lookup starts with a one-cycle strobe. The strobe carries the destination address and the frame length, and four mode controls are sampled with it: promiscuous, receive-all, pass-all-multicast and inverse filtering. The block compares the address against one table entry per clock. After the scan it gives a verdict: accept or reject. It also gives two status flags for the receive descriptor. One flag says the frame passed without filtering. The other says it passed because it was multicast.

The verdict follows a fixed priority. A short frame is rejected first. The broadcast address is then accepted with no flags. Promiscuous or receive-all comes next, then pass-all-multicast. Only after these is the perfect-match table consulted, and its result can be inverted.

Top module: `station_addr_filter`

## Requirements
- R1: After reset, every table entry is all zeros, and `done`, `accept`, `flag_filt_fail`, `flag_mcast` and `setup_busy` are low. A lookup of address zero with no mode set is therefore accepted before any load.
- R2: A setup frame is applied only when the length given with `setup_start` is exactly 192 (16 slots of 12 bytes). Any other length leaves all sixteen entries unchanged, and the bytes that follow are ignored.
- R3: Setup byte `12*n + s` feeds entry `n`. Slot bytes s = 0, 1, 4, 5, 8, 9 become address bytes 0 to 5 in that order. The other slot bytes are ignored. Address byte k occupies bits [8k+7:8k] of an entry and of `lookup_addr`, so address byte 0 (the first byte on the wire) is bits [7:0].
- R4: The all-ones address with a length of at least 14 is accepted with both flags low, whatever the modes are.
- R5: If R4 does not apply and promiscuous or receive-all is set, the frame is accepted with `flag_filt_fail` high and `flag_mcast` low.
- R6: If R4 and R5 do not apply, pass-all-multicast is set, and bit 0 of address byte 0 (bit 0 of `lookup_addr`) is 1, the frame is accepted with `flag_mcast` high and `flag_filt_fail` low.
- R7: Otherwise `accept` equals "matches any of the 16 entries" XOR inverse, and both flags are low.
- R8: A lookup with a length below 14 is rejected with both flags low, even for the broadcast address.
- R9: `done` is a one-cycle pulse in the 16th clock after the edge that accepts `lookup_start`. The verdict outputs change only together with `done` and hold their values until the next `done`.
- R10: A `lookup_start` that arrives while a lookup is in progress is ignored, so it changes neither the verdict nor the timing of the lookup already running.
- R11: `setup_busy` rises on the edge that accepts a 192-byte setup and falls on the edge that takes in byte 191. A `setup_start` that arrives while `setup_busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_start | input | 1 | Begins a setup frame; `setup_len` is sampled with it |
| setup_len | input | 12 | Setup frame length in bytes |
| setup_valid | input | 1 | A setup byte is present on `setup_byte` |
| setup_byte | input | 8 | Setup frame byte, in stream order |
| setup_busy | output | 1 | A valid setup frame is being taken in |
| lookup_start | input | 1 | Begins a lookup; address, length and modes are sampled with it |
| lookup_addr | input | 48 | Destination address, byte 0 in bits [7:0] |
| lookup_len | input | 12 | Received frame length in bytes |
| mode_promisc | input | 1 | Promiscuous mode |
| mode_rx_all | input | 1 | Receive-all mode |
| mode_pass_mcast | input | 1 | Pass all multicast frames |
| mode_inverse | input | 1 | Invert the perfect-match result |
| done | output | 1 | One-cycle pulse: the verdict is valid |
| accept | output | 1 | Frame accepted |
| flag_filt_fail | output | 1 | Accepted without filtering (promiscuous or receive-all) |
| flag_mcast | output | 1 | Accepted as multicast under pass-all-multicast |

## Verification
Some internal faults show up at the ports only after a setup load. These are a wrong lane map, a wrong slot counter, or a table written on a bad length. The fault appears as a wrong verdict on the first lookup of an address built from the affected slot, 16 cycles after its start. Using a distinct byte value in every lane and every slot lets each misplaced byte change some verdict. Setting the padding lanes to a non-address value makes an unskipped lane shift every later address byte.

Faults in the scan sequencer have different signatures. A sequencer that stops early or runs late moves `done` off the 16-cycle point on every lookup. One that skips an entry misses exactly that entry's address. Faults in the priority order show up as a broken flag combination on the first lookup that combines the modes involved.

// File: rtl/saf_pkg.sv
package saf_pkg;

    localparam int MAC_W       = 48;
    localparam int BYTE_W      = 8;
    localparam int SLOT_BYTES  = 12;
    localparam int ADDR_BYTES  = 6;
    localparam int MIN_FRAME   = 14;

    typedef logic [MAC_W-1:0] mac_t;

    typedef struct packed {
        logic promisc;
        logic rx_all;
        logic pass_mcast;
        logic inverse;
    } mode_t;

    typedef struct packed {
        logic accept;
        logic filt_fail;
        logic mcast;
    } verdict_t;

    typedef struct packed {
        logic       used;
        logic [2:0] lane;
    } lane_t;

    // Position inside a 12-byte slot -> address byte lane (or unused)
    function automatic lane_t lane_of(input logic [3:0] pos);
        lane_t l;
        l.used = 1'b1;
        case (pos)
            4'd0:    l.lane = 3'd0;
            4'd1:    l.lane = 3'd1;
            4'd4:    l.lane = 3'd2;
            4'd5:    l.lane = 3'd3;
            4'd8:    l.lane = 3'd4;
            4'd9:    l.lane = 3'd5;
            default: begin
                l.used = 1'b0;
                l.lane = 3'd0;
            end
        endcase
        return l;
    endfunction

    // Priority: short frame, broadcast, promiscuous/all, multicast, match
    function automatic verdict_t judge(input mac_t addr, input logic short_frame,
                                       input mode_t m, input logic hit);
        verdict_t v;
        v = '0;
        if (short_frame) begin
            v = '0;
        end else if (&addr) begin
            v.accept = 1'b1;
        end else if (m.promisc || m.rx_all) begin
            v.accept    = 1'b1;
            v.filt_fail = 1'b1;
        end else if (m.pass_mcast && addr[0]) begin
            v.accept = 1'b1;
            v.mcast  = 1'b1;
        end else begin
            v.accept = hit ^ m.inverse;
        end
        return v;
    endfunction

endpackage

// File: rtl/saf_loader.sv
module saf_loader
    import saf_pkg::*;
#(
    parameter int N_ENT = 16,
    parameter int LEN_W = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     setup_start,
    input  logic [LEN_W-1:0]         setup_len,
    input  logic                     setup_valid,
    input  logic [BYTE_W-1:0]        setup_byte,
    output logic                     busy,
    output logic                     wr_en,
    output logic [$clog2(N_ENT)-1:0] wr_slot,
    output logic [2:0]               wr_lane,
    output logic [BYTE_W-1:0]        wr_data
);
    localparam int IDX_W     = $clog2(N_ENT);
    localparam int SETUP_LEN = N_ENT * SLOT_BYTES;

    logic [IDX_W-1:0] slot_q;
    logic [3:0]       pos_q;
    lane_t            cur;
    logic             take;
    logic             last_byte;

    assign cur       = lane_of(pos_q);
    assign take      = busy && setup_valid;
    assign last_byte = take && (slot_q == IDX_W'(N_ENT - 1))
                            && (pos_q == 4'(SLOT_BYTES - 1));

    assign wr_en   = take && cur.used;
    assign wr_slot = slot_q;
    assign wr_lane = cur.lane;
    assign wr_data = setup_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            slot_q <= '0;
            pos_q  <= '0;
        end else if (!busy) begin
            if (setup_start && (setup_len == LEN_W'(SETUP_LEN))) begin
                busy   <= 1'b1;
                slot_q <= '0;
                pos_q  <= '0;
            end
        end else if (take) begin
            if (last_byte) begin
                busy <= 1'b0;
            end
            if (pos_q == 4'(SLOT_BYTES - 1)) begin
                pos_q  <= '0;
                slot_q <= slot_q + 1'b1;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/saf_table.sv
module saf_table
    import saf_pkg::*;
#(
    parameter int N_ENT = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [$clog2(N_ENT)-1:0] wr_slot,
    input  logic [2:0]               wr_lane,
    input  logic [BYTE_W-1:0]        wr_data,
    input  logic [$clog2(N_ENT)-1:0] rd_idx,
    output mac_t                     rd_entry
);
    mac_t ent [N_ENT];

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent[g] <= '0;
            end else if (wr_en && (wr_slot == $clog2(N_ENT)'(g))) begin
                ent[g][wr_lane*BYTE_W +: BYTE_W] <= wr_data;
            end
        end
    end

    assign rd_entry = ent[rd_idx];
endmodule

// File: rtl/saf_scan.sv
module saf_scan
    import saf_pkg::*;
#(
    parameter int N_ENT = 16,
    parameter int LEN_W = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  mac_t                     addr,
    input  logic [LEN_W-1:0]         len,
    input  mode_t                    mode,
    input  mac_t                     entry,
    output logic [$clog2(N_ENT)-1:0] rd_idx,
    output logic                     done,
    output verdict_t                 verdict
);
    localparam int IDX_W = $clog2(N_ENT);

    typedef enum logic {S_IDLE, S_SCAN} state_t;

    state_t           state;
    logic [IDX_W-1:0] idx_q;
    logic             hit_q;
    mac_t             addr_q;
    logic             short_q;
    mode_t            mode_q;
    logic             match;

    assign match  = (entry == addr_q);
    assign rd_idx = idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            idx_q   <= '0;
            hit_q   <= 1'b0;
            addr_q  <= '0;
            short_q <= 1'b0;
            mode_q  <= '0;
            done    <= 1'b0;
            verdict <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        state   <= S_SCAN;
                        idx_q   <= '0;
                        hit_q   <= 1'b0;
                        addr_q  <= addr;
                        short_q <= (len < LEN_W'(MIN_FRAME));
                        mode_q  <= mode;
                    end
                end
                S_SCAN: begin
                    if (idx_q == IDX_W'(N_ENT - 1)) begin
                        state   <= S_IDLE;
                        done    <= 1'b1;
                        verdict <= judge(addr_q, short_q, mode_q, hit_q | match);
                    end else begin
                        idx_q <= idx_q + 1'b1;
                        hit_q <= hit_q | match;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/station_addr_filter.sv
module station_addr_filter
    import saf_pkg::*;
#(
    parameter int N_ENT = 16,
    parameter int LEN_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              setup_start,
    input  logic [LEN_W-1:0]  setup_len,
    input  logic              setup_valid,
    input  logic [7:0]        setup_byte,
    output logic              setup_busy,
    input  logic              lookup_start,
    input  logic [47:0]       lookup_addr,
    input  logic [LEN_W-1:0]  lookup_len,
    input  logic              mode_promisc,
    input  logic              mode_rx_all,
    input  logic              mode_pass_mcast,
    input  logic              mode_inverse,
    output logic              done,
    output logic              accept,
    output logic              flag_filt_fail,
    output logic              flag_mcast
);
    localparam int IDX_W = $clog2(N_ENT);

    logic              wr_en;
    logic [IDX_W-1:0]  wr_slot;
    logic [2:0]        wr_lane;
    logic [BYTE_W-1:0] wr_data;
    logic [IDX_W-1:0]  rd_idx;
    mac_t              rd_entry;
    mode_t             mode;
    verdict_t          verdict;

    assign mode = '{promisc: mode_promisc, rx_all: mode_rx_all,
                    pass_mcast: mode_pass_mcast, inverse: mode_inverse};

    saf_loader #(.N_ENT(N_ENT), .LEN_W(LEN_W)) u_loader (
        .clk(clk), .rst(rst),
        .setup_start(setup_start), .setup_len(setup_len),
        .setup_valid(setup_valid), .setup_byte(setup_byte),
        .busy(setup_busy),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_lane(wr_lane), .wr_data(wr_data)
    );

    saf_table #(.N_ENT(N_ENT)) u_table (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_lane(wr_lane), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_entry(rd_entry)
    );

    saf_scan #(.N_ENT(N_ENT), .LEN_W(LEN_W)) u_scan (
        .clk(clk), .rst(rst),
        .start(lookup_start), .addr(lookup_addr), .len(lookup_len), .mode(mode),
        .entry(rd_entry), .rd_idx(rd_idx),
        .done(done), .verdict(verdict)
    );

    assign accept         = verdict.accept;
    assign flag_filt_fail = verdict.filt_fail;
    assign flag_mcast     = verdict.mcast;
endmodule

// File: rtl/saf_checker.sv
module saf_checker #(
    parameter int N_ENT = 16,
    parameter int LEN_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             setup_start,
    input logic [LEN_W-1:0] setup_len,
    input logic             setup_busy,
    input logic             lookup_start,
    input logic             done,
    input logic             accept,
    input logic             flag_filt_fail,
    input logic             flag_mcast
);
    localparam int SETUP_LEN = N_ENT * 12;
    localparam int CNT_W     = $clog2(N_ENT + 2);

    logic             pending;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            cnt     <= '0;
        end else if (lookup_start && (!pending || done)) begin
            pending <= 1'b1;
            cnt     <= '0;
        end else if (done) begin
            pending <= 1'b0;
        end else if (pending && cnt != {CNT_W{1'b1}}) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R9 / R10: done comes exactly N_ENT cycles after an accepted start
    assert_done_latency_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (pending && cnt == CNT_W'(N_ENT)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_verdict_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable({accept, flag_filt_fail, flag_mcast}));

    assert_flag_implies_accept_R5: assert property (@(posedge clk) disable iff (rst)
        (flag_filt_fail || flag_mcast) |-> accept);

    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(flag_filt_fail && flag_mcast));

    assert_bad_len_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (!setup_busy && setup_start && setup_len != LEN_W'(SETUP_LEN)) |=> !setup_busy);
endmodule

bind station_addr_filter saf_checker #(.N_ENT(N_ENT), .LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst(rst),
    .setup_start(setup_start), .setup_len(setup_len), .setup_busy(setup_busy),
    .lookup_start(lookup_start), .done(done), .accept(accept),
    .flag_filt_fail(flag_filt_fail), .flag_mcast(flag_mcast)
);

// File: tb/station_addr_filter_tb.sv
module station_addr_filter_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        setup_start = 1'b0;
    logic [11:0] setup_len = '0;
    logic        setup_valid = 1'b0;
    logic [7:0]  setup_byte = '0;
    logic        setup_busy;
    logic        lookup_start = 1'b0;
    logic [47:0] lookup_addr = '0;
    logic [11:0] lookup_len = '0;
    logic        mode_promisc = 1'b0, mode_rx_all = 1'b0;
    logic        mode_pass_mcast = 1'b0, mode_inverse = 1'b0;
    logic        done, accept, flag_filt_fail, flag_mcast;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    station_addr_filter u_dut (.*);

    // {addr48, len12, modes{promisc,rx_all,pass_mcast,inverse}, expected{accept,ff,mc}}
    localparam int NV = 13;
    localparam logic [66:0] VEC [NV] = '{
        {48'h050403020100, 12'd64, 4'b0000, 3'b100},  // R7 entry 0
        {48'hF5F4F3F2F1F0, 12'd64, 4'b0000, 3'b100},  // R7 entry 15
        {48'h050403020101, 12'd64, 4'b0000, 3'b000},  // R7 multicast, no match
        {48'h050403020101, 12'd64, 4'b0010, 3'b101},  // R6
        {48'h555453525150, 12'd64, 4'b0001, 3'b000},  // R7 inverse on hit
        {48'h000000000002, 12'd64, 4'b0001, 3'b100},  // R7 inverse on miss
        {48'hFFFFFFFFFFFF, 12'd64, 4'b1000, 3'b100},  // R4 broadcast beats promisc
        {48'h000000000002, 12'd64, 4'b1000, 3'b110},  // R5 promisc
        {48'h000000000002, 12'd64, 4'b0100, 3'b110},  // R5 receive-all
        {48'hFFFFFFFFFFFF, 12'd13, 4'b0000, 3'b000},  // R8 short broadcast
        {48'h757473727170, 12'd14, 4'b0000, 3'b100},  // R8 boundary length 14
        {48'h050403020101, 12'd64, 4'b1010, 3'b110},  // R5 over R6
        {48'h565453525150, 12'd64, 4'b0000, 3'b000}   // R3 near miss, top byte
    };

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic lookup(input logic [47:0] a, input logic [11:0] l, input logic [3:0] m,
                          output logic [2:0] res, output int lat);
        @(negedge clk);
        lookup_addr = a;
        lookup_len = l;
        {mode_promisc, mode_rx_all, mode_pass_mcast, mode_inverse} = m;
        lookup_start = 1'b1;
        @(negedge clk);
        lookup_start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        res = {accept, flag_filt_fail, flag_mcast};
    endtask

    // Setup stream byte: slot n, lane k -> {n, k}; padding lanes 0xEE
    function automatic logic [7:0] setup_val(input int i);
        int n = i / 12;
        int p = i % 12;
        case (p)
            0: return {n[3:0], 4'd0};
            1: return {n[3:0], 4'd1};
            4: return {n[3:0], 4'd2};
            5: return {n[3:0], 4'd3};
            8: return {n[3:0], 4'd4};
            9: return {n[3:0], 4'd5};
            default: return 8'hEE;
        endcase
    endfunction

    task automatic send_setup(input int len_field, input int nbytes, output logic busy_seen);
        @(negedge clk);
        setup_len = 12'(len_field);
        setup_start = 1'b1;
        @(negedge clk);
        setup_start = 1'b0;
        busy_seen = setup_busy;
        for (int i = 0; i < nbytes; i++) begin
            setup_valid = 1'b1;
            setup_byte = setup_val(i);
            @(negedge clk);
        end
        setup_valid = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [2:0] res;
        int lat;
        logic busy_seen;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset outputs", {done, accept, flag_filt_fail, flag_mcast, setup_busy}, 0);

        lookup(48'h0, 12'd64, 4'b0000, res, lat);
        chk("R1 zero table matches address 0", res, 3'b100);
        chk("R9 latency", lat, 17);

        send_setup(191, 191, busy_seen);
        chk("R11 busy low on bad length", {busy_seen, setup_busy}, 0);
        lookup(48'h050403020100, 12'd64, 4'b0000, res, lat);
        chk("R2 bad length leaves table", res, 3'b000);
        lookup(48'h0, 12'd64, 4'b0000, res, lat);
        chk("R2 bad length keeps zero entry", res, 3'b100);

        send_setup(192, 192, busy_seen);
        chk("R11 busy during load", busy_seen, 1);
        chk("R11 busy after last byte", setup_busy, 0);
        lookup(48'h0, 12'd64, 4'b0000, res, lat);
        chk("R3 zero entry overwritten", res, 3'b000);

        for (int v = 0; v < NV; v++) begin
            lookup(VEC[v][66:19], VEC[v][18:7], VEC[v][6:3], res, lat);
            chk($sformatf("R4-8 vector %0d", v), res, VEC[v][2:0]);
            chk("R9 latency vector", lat, 17);
        end

        // R9 hold: verdict stays after done
        lookup(48'h000000000002, 12'd64, 4'b1000, res, lat);
        repeat (5) @(negedge clk);
        chk("R9 verdict held", {done, accept, flag_filt_fail, flag_mcast}, 4'b0110);

        // R10 second start during a lookup is ignored
        @(negedge clk);
        lookup_addr = 48'h050403020100;
        lookup_len = 12'd64;
        {mode_promisc, mode_rx_all, mode_pass_mcast, mode_inverse} = 4'b0000;
        lookup_start = 1'b1;
        @(negedge clk);
        lookup_addr = 48'h000000000002;
        @(negedge clk);
        lookup_start = 1'b0;
        lat = 2;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk("R10 ignored start verdict", {accept, flag_filt_fail, flag_mcast}, 3'b100);
        chk("R10 ignored start latency", lat, 17);
        @(negedge clk);
        chk("R10 single done pulse", done, 0);

        // R2 overlong length also ignored
        send_setup(200, 200, busy_seen);
        chk("R2 length 200 not busy", busy_seen, 0);
        lookup(48'hA5A4A3A2A1A0, 12'd64, 4'b0000, res, lat);
        chk("R2 length 200 table kept", res, 3'b100);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule